// File: doc/BRIEF.md
# Baccarat Dealing Controller and Scorer

This block plays one hand of baccarat, one step per clock tick. Each tick it either latches the 4-bit card code present on its card input into the next hand slot, or it makes one of the drawing decisions the game calls for. Card generation sits outside the block. Whatever source feeds the card input supplies a fresh code before each tick, and the block decides whether that code is taken or ignored.

Each hand has three slots, and each slot drives one seven-segment digit. The block keeps both hand scores modulo 10 as cards arrive and shows them on a 10-bit LED word. After four cards it checks for a natural. It then applies the player's third-card rule, followed by the dealer's third-card table. Last, it records the winner in the two top LED bits and holds the finished hand until reset.

Top module: `baccaratDealer`

## Requirements
- R1: A clock edge with `rstN` low blanks all six digits (all segments off, 7'b1111111) and clears all ten LED bits.
- R2: After reset, the first four ticks latch `cardIn` into, in this order: player slot 1, dealer slot 1, player slot 2, dealer slot 2.
- R3: Player slots 1 to 3 drive `playerSeg0` to `playerSeg2`, and dealer slots 1 to 3 drive `dealerSeg0` to `dealerSeg2`. A slot that holds no card shows blank.
- R4: Digits are active-low, with bit 6 = segment g down to bit 0 = segment a. The patterns are:
  - ace (code 1): 0001000
  - 2: 0100100
  - 3: 0110000
  - 4: 0011001
  - 5: 0010010
  - 6: 0000010
  - 7: 1111000
  - 8: 0000000
  - 9: 0010000
  - 10: 1000000
  - jack (11): 1100001
  - queen (12): 0011000
  - king (13): 0001001
  - codes 0, 14 and 15: blank 1111111
- R5: `ledOut[3:0]` carries the player score and `ledOut[7:4]` the dealer score. Both are visible right after the tick that latched a card.
- R6: Card points are as follows: ace is 1, codes 2 to 9 count their face value, and 10, jack, queen and king count 0. Codes 0, 14 and 15 also count 0. A hand scores the sum of its points modulo 10.
- R7: On the fifth tick, if either two-card hand scores 8 or 9, the winner is written on that tick. No third card is taken, and `cardIn` is ignored.
- R8: Without a natural, the fifth tick latches the player's third card if the player scores 0 to 5. On 6 or 7 that tick takes no card.
- R9: On the sixth tick, the dealer takes a third card according to the rules below; otherwise the winner is written on that tick. If the dealer draws, the winner is written on the seventh tick.
  - If the player stood: the dealer draws on 0 to 5.
  - If the player drew a card worth t points:
    - dealer on 0 to 2: draws
    - dealer on 3: draws unless t is 8
    - dealer on 4: draws when t is 2 to 7
    - dealer on 5: draws when t is 4 to 7
    - dealer on 6: draws when t is 6 or 7
    - dealer on 7: stands
- R10: The winner is encoded in `ledOut[9:8]`: 01 means the player wins, 10 means the dealer wins, and 11 means a tie.
- R11: Once the winner is written, all outputs hold and `cardIn` is ignored until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dealing tick; one game step per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cardIn | input | 4 | Card code offered for the current tick |
| playerSeg0 | output | 7 | Player slot 1 digit, active-low |
| playerSeg1 | output | 7 | Player slot 2 digit, active-low |
| playerSeg2 | output | 7 | Player slot 3 digit, active-low |
| dealerSeg0 | output | 7 | Dealer slot 1 digit, active-low |
| dealerSeg1 | output | 7 | Dealer slot 2 digit, active-low |
| dealerSeg2 | output | 7 | Dealer slot 3 digit, active-low |
| ledOut | output | 10 | {winner flags, dealer score, player score} |

## Verification
The bench builds the block with its default sizing: three slots per hand, 4-bit card codes and 4-bit scores. That is the only sizing the six fixed digit ports allow. With codes drawn across the full 0 to 15 range, random hands reach:
- every branch of the dealer table;
- naturals on either side;
- the blank codes, which score zero.

Directed hands pin down the corners that random play reaches only rarely: a dealer on 3 facing a player's third card of 8, a standing player that forces an idle tick, a tie, and a reset in mid-deal.

// File: rtl/baccaratPkg.sv
package baccaratPkg;

  localparam int CARD_W         = 4;
  localparam int SEG_W          = 7;
  localparam int SCORE_W        = 4;
  localparam int SLOTS_PER_HAND = 3;
  localparam int NUM_SLOTS      = 2 * SLOTS_PER_HAND;
  localparam int PLAYER_BASE    = 0;
  localparam int DEALER_BASE    = SLOTS_PER_HAND;
  localparam int THIRD_POS      = SLOTS_PER_HAND - 1;
  localparam int MAX_POINTS     = 9;
  localparam int SUM_W          = $clog2(MAX_POINTS * SLOTS_PER_HAND + 1);
  localparam int LED_W          = 2 * SCORE_W + 2;

  typedef enum logic [2:0] {
    ST_P1,
    ST_D1,
    ST_P2,
    ST_D2,
    ST_PDRAW,
    ST_DDRAW,
    ST_SETTLE,
    ST_DONE
  } dealState_t;

  typedef struct packed {
    logic [NUM_SLOTS-1:0] loadSlot;
    logic                 setResult;
  } dpStrobe_t;

  function automatic logic [SCORE_W-1:0] cardPoints(input logic [CARD_W-1:0] code);
    if (code >= CARD_W'(1) && code <= CARD_W'(9)) return SCORE_W'(code);
    return '0;
  endfunction

  function automatic logic [SCORE_W-1:0] modTen(input logic [SUM_W-1:0] sum);
    logic [SUM_W-1:0] rem;
    rem = sum;
    for (int i = 0; i < SLOTS_PER_HAND; i++) begin
      if (rem >= SUM_W'(10)) rem = rem - SUM_W'(10);
    end
    return SCORE_W'(rem);
  endfunction

  function automatic logic [SEG_W-1:0] cardGlyph(input logic [CARD_W-1:0] code);
    logic [SEG_W-1:0] g;
    case (code)
      CARD_W'(1):  g = 7'b0001000;
      CARD_W'(2):  g = 7'b0100100;
      CARD_W'(3):  g = 7'b0110000;
      CARD_W'(4):  g = 7'b0011001;
      CARD_W'(5):  g = 7'b0010010;
      CARD_W'(6):  g = 7'b0000010;
      CARD_W'(7):  g = 7'b1111000;
      CARD_W'(8):  g = 7'b0000000;
      CARD_W'(9):  g = 7'b0010000;
      CARD_W'(10): g = 7'b1000000;
      CARD_W'(11): g = 7'b1100001;
      CARD_W'(12): g = 7'b0011000;
      CARD_W'(13): g = 7'b0001001;
      default:     g = 7'b1111111;
    endcase
    return g;
  endfunction

  function automatic logic dealerDraws(input logic [SCORE_W-1:0] bank,
                                       input logic               playerDrew,
                                       input logic [SCORE_W-1:0] third);
    logic take;
    if (!playerDrew) begin
      take = (bank <= SCORE_W'(5));
    end else begin
      case (bank)
        SCORE_W'(0), SCORE_W'(1), SCORE_W'(2): take = 1'b1;
        SCORE_W'(3): take = (third != SCORE_W'(8));
        SCORE_W'(4): take = (third >= SCORE_W'(2)) && (third <= SCORE_W'(7));
        SCORE_W'(5): take = (third >= SCORE_W'(4)) && (third <= SCORE_W'(7));
        SCORE_W'(6): take = (third == SCORE_W'(6)) || (third == SCORE_W'(7));
        default:     take = 1'b0;
      endcase
    end
    return take;
  endfunction

endpackage

// File: rtl/baccaratGlyph.sv
module baccaratGlyph
  import baccaratPkg::*;
(
  input  logic [CARD_W-1:0] code,
  output logic [SEG_W-1:0]  seg
);

  always_comb seg = cardGlyph(code);

endmodule

// File: rtl/baccaratDatapath.sv
module baccaratDatapath
  import baccaratPkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [CARD_W-1:0]                  cardIn,
  input  dpStrobe_t                          strb,
  output logic [NUM_SLOTS-1:0][CARD_W-1:0]   cards,
  output logic [SCORE_W-1:0]                 playerScore,
  output logic [SCORE_W-1:0]                 dealerScore,
  output logic [SCORE_W-1:0]                 playerThirdPts,
  output logic [1:0]                         winFlags
);

  logic [SUM_W-1:0] playerSum;
  logic [SUM_W-1:0] dealerSum;

  // card slot registers, one load strobe each
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cards <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (strb.loadSlot[i]) cards[i] <= cardIn;
      end
    end
  end

  // hand totals are recomputed from the slots, so no accumulator to keep coherent
  always_comb begin
    playerSum = '0;
    dealerSum = '0;
    for (int i = 0; i < SLOTS_PER_HAND; i++) begin
      playerSum = playerSum + SUM_W'(cardPoints(cards[PLAYER_BASE + i]));
      dealerSum = dealerSum + SUM_W'(cardPoints(cards[DEALER_BASE + i]));
    end
    playerScore    = modTen(playerSum);
    dealerScore    = modTen(dealerSum);
    playerThirdPts = cardPoints(cards[PLAYER_BASE + THIRD_POS]);
  end

  // winner flags: bit 0 player, bit 1 dealer, both for a tie
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winFlags <= 2'b00;
    end else if (strb.setResult) begin
      if (playerScore > dealerScore)      winFlags <= 2'b01;
      else if (dealerScore > playerScore) winFlags <= 2'b10;
      else                                winFlags <= 2'b11;
    end
  end

  // R6
  score_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (playerScore < SCORE_W'(10)) && (dealerScore < SCORE_W'(10)));

  // R10
  result_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setResult |=> (winFlags != 2'b00));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winFlags != 2'b00) |=> ($stable(winFlags) && $stable(cards)));

endmodule

// File: rtl/baccaratCtrl.sv
module baccaratCtrl
  import baccaratPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SCORE_W-1:0] playerScore,
  input  logic [SCORE_W-1:0] dealerScore,
  input  logic [SCORE_W-1:0] playerThirdPts,
  output dpStrobe_t          strb
);

  localparam int P_THIRD = PLAYER_BASE + THIRD_POS;
  localparam int D_THIRD = DEALER_BASE + THIRD_POS;

  dealState_t state;
  dealState_t stateNext;
  logic       playerDrew;
  logic       natural;

  always_comb natural = (playerScore >= SCORE_W'(8)) || (dealerScore >= SCORE_W'(8));

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      ST_P1: begin
        strb.loadSlot[PLAYER_BASE] = 1'b1;
        stateNext = ST_D1;
      end
      ST_D1: begin
        strb.loadSlot[DEALER_BASE] = 1'b1;
        stateNext = ST_P2;
      end
      ST_P2: begin
        strb.loadSlot[PLAYER_BASE + 1] = 1'b1;
        stateNext = ST_D2;
      end
      ST_D2: begin
        strb.loadSlot[DEALER_BASE + 1] = 1'b1;
        stateNext = ST_PDRAW;
      end
      ST_PDRAW: begin
        if (natural) begin
          strb.setResult = 1'b1;
          stateNext = ST_DONE;
        end else begin
          strb.loadSlot[P_THIRD] = (playerScore <= SCORE_W'(5));
          stateNext = ST_DDRAW;
        end
      end
      ST_DDRAW: begin
        if (dealerDraws(dealerScore, playerDrew, playerThirdPts)) begin
          strb.loadSlot[D_THIRD] = 1'b1;
          stateNext = ST_SETTLE;
        end else begin
          strb.setResult = 1'b1;
          stateNext = ST_DONE;
        end
      end
      ST_SETTLE: begin
        strb.setResult = 1'b1;
        stateNext = ST_DONE;
      end
      default: stateNext = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_P1;
      playerDrew <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.loadSlot[P_THIRD]) playerDrew <= 1'b1;
    end
  end

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> ((state == ST_DONE) && (strb.loadSlot == '0) && !strb.setResult));

  // R7
  natural_no_third_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSlot[P_THIRD] |-> ((playerScore < SCORE_W'(8)) && (dealerScore < SCORE_W'(8))));

  // R8
  player_third_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSlot[P_THIRD] |-> (playerScore <= SCORE_W'(5)));

  // R9
  dealer_third_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSlot[D_THIRD] |-> (dealerScore <= SCORE_W'(6)));

  // R2
  single_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setResult && (strb.loadSlot != '0)));

endmodule

// File: rtl/baccaratDealer.sv
module baccaratDealer
  import baccaratPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CARD_W-1:0] cardIn,
  output logic [SEG_W-1:0]  playerSeg0,
  output logic [SEG_W-1:0]  playerSeg1,
  output logic [SEG_W-1:0]  playerSeg2,
  output logic [SEG_W-1:0]  dealerSeg0,
  output logic [SEG_W-1:0]  dealerSeg1,
  output logic [SEG_W-1:0]  dealerSeg2,
  output logic [LED_W-1:0]  ledOut
);

  dpStrobe_t                        strb;
  logic [NUM_SLOTS-1:0][CARD_W-1:0] cards;
  logic [NUM_SLOTS-1:0][SEG_W-1:0]  segAll;
  logic [SCORE_W-1:0]               playerScore;
  logic [SCORE_W-1:0]               dealerScore;
  logic [SCORE_W-1:0]               playerThirdPts;
  logic [1:0]                       winFlags;

  baccaratCtrl ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .playerScore    (playerScore),
    .dealerScore    (dealerScore),
    .playerThirdPts (playerThirdPts),
    .strb           (strb)
  );

  baccaratDatapath dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .cardIn         (cardIn),
    .strb           (strb),
    .cards          (cards),
    .playerScore    (playerScore),
    .dealerScore    (dealerScore),
    .playerThirdPts (playerThirdPts),
    .winFlags       (winFlags)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_glyph
    baccaratGlyph glyph_i (
      .code (cards[s]),
      .seg  (segAll[s])
    );
  end

  assign playerSeg0 = segAll[PLAYER_BASE];
  assign playerSeg1 = segAll[PLAYER_BASE + 1];
  assign playerSeg2 = segAll[PLAYER_BASE + 2];
  assign dealerSeg0 = segAll[DEALER_BASE];
  assign dealerSeg1 = segAll[DEALER_BASE + 1];
  assign dealerSeg2 = segAll[DEALER_BASE + 2];
  assign ledOut     = {winFlags, dealerScore, playerScore};

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> ((ledOut == '0) && (playerSeg0 == 7'b1111111) && (dealerSeg0 == 7'b1111111)));

endmodule

// File: tb/baccaratDealer_tb_top.sv
module baccaratDealer_tb_top;

  logic       clk;
  logic       rstN;
  logic [3:0] cardIn;
  logic [6:0] playerSeg0, playerSeg1, playerSeg2;
  logic [6:0] dealerSeg0, dealerSeg1, dealerSeg2;
  logic [9:0] ledOut;

  int  checkCount = 0;
  int  failCount  = 0;
  bit  finished   = 0;

  // reference model state
  logic [3:0] mCard [6];
  int         mStep;
  bit         mDrew;
  logic [1:0] mWin;

  baccaratDealer dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .cardIn     (cardIn),
    .playerSeg0 (playerSeg0),
    .playerSeg1 (playerSeg1),
    .playerSeg2 (playerSeg2),
    .dealerSeg0 (dealerSeg0),
    .dealerSeg1 (dealerSeg1),
    .dealerSeg2 (dealerSeg2),
    .ledOut     (ledOut)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int refPts(input logic [3:0] c);
    if (c >= 1 && c <= 9) return int'(c);
    return 0;
  endfunction

  function automatic int refScore(input int base);
    int s = 0;
    for (int i = 0; i < 3; i++) s += refPts(mCard[base + i]);
    return s % 10;
  endfunction

  function automatic logic [6:0] refGlyph(input logic [3:0] c);
    case (c)
      4'd1:  return 7'b0001000;
      4'd2:  return 7'b0100100;
      4'd3:  return 7'b0110000;
      4'd4:  return 7'b0011001;
      4'd5:  return 7'b0010010;
      4'd6:  return 7'b0000010;
      4'd7:  return 7'b1111000;
      4'd8:  return 7'b0000000;
      4'd9:  return 7'b0010000;
      4'd10: return 7'b1000000;
      4'd11: return 7'b1100001;
      4'd12: return 7'b0011000;
      4'd13: return 7'b0001001;
      default: return 7'b1111111;
    endcase
  endfunction

  function automatic bit refBankTakes(input int b, input bit drew, input int t);
    if (!drew) return b <= 5;
    if (b <= 2) return 1;
    if (b == 3) return t != 8;
    if (b == 4) return t >= 2 && t <= 7;
    if (b == 5) return t >= 4 && t <= 7;
    if (b == 6) return t == 6 || t == 7;
    return 0;
  endfunction

  function automatic logic [1:0] refWinner();
    int p = refScore(0);
    int d = refScore(3);
    if (p > d) return 2'b01;
    if (d > p) return 2'b10;
    return 2'b11;
  endfunction

  task automatic modelClear();
    for (int i = 0; i < 6; i++) mCard[i] = 4'd0;
    mStep = 0;
    mDrew = 0;
    mWin  = 2'b00;
  endtask

  task automatic modelStep(input logic [3:0] c);
    case (mStep)
      0: begin mCard[0] = c; mStep = 1; end
      1: begin mCard[3] = c; mStep = 2; end
      2: begin mCard[1] = c; mStep = 3; end
      3: begin mCard[4] = c; mStep = 4; end
      4: begin
        if (refScore(0) >= 8 || refScore(3) >= 8) begin
          mWin = refWinner(); mStep = 7;
        end else begin
          if (refScore(0) <= 5) begin mCard[2] = c; mDrew = 1; end
          mStep = 5;
        end
      end
      5: begin
        if (refBankTakes(refScore(3), mDrew, refPts(mCard[2]))) begin
          mCard[5] = c; mStep = 6;
        end else begin
          mWin = refWinner(); mStep = 7;
        end
      end
      6: begin mWin = refWinner(); mStep = 7; end
      default: mStep = 7;
    endcase
  endtask

  task automatic check(input string tag, input logic [69:0] got, input logic [69:0] exp);
    checkCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  // one tick: drive away from the edge, update model at the edge, sample at the falling edge
  task automatic tick(input logic rstVal, input logic [3:0] c);
    string segTag, ledTag;
    rstN   = rstVal;
    cardIn = c;
    if (!rstVal)          begin segTag = "R1"; ledTag = "R1"; end
    else if (mStep <= 3)  begin segTag = "R2 R3 R4"; ledTag = "R5 R6"; end
    else if (mStep == 4)  begin segTag = "R7 R8"; ledTag = "R7 R10"; end
    else if (mStep == 5)  begin segTag = "R9"; ledTag = "R9 R10"; end
    else if (mStep == 6)  begin segTag = "R10"; ledTag = "R10"; end
    else                  begin segTag = "R11"; ledTag = "R11"; end
    @(posedge clk);
    if (!rstVal) modelClear();
    else         modelStep(c);
    @(negedge clk);
    check(segTag,
          {28'd0, playerSeg0, playerSeg1, playerSeg2, dealerSeg0, dealerSeg1, dealerSeg2},
          {28'd0, refGlyph(mCard[0]), refGlyph(mCard[1]), refGlyph(mCard[2]),
                  refGlyph(mCard[3]), refGlyph(mCard[4]), refGlyph(mCard[5])});
    check(ledTag, {60'd0, ledOut},
          {60'd0, mWin, 4'(refScore(3)), 4'(refScore(0))});
  endtask

  task automatic playHand(input logic [3:0] c0, input logic [3:0] c1, input logic [3:0] c2,
                          input logic [3:0] c3, input logic [3:0] c4, input logic [3:0] c5,
                          input logic [3:0] c6, input logic [3:0] c7);
    tick(1'b0, 4'd0);
    tick(1'b1, c0); tick(1'b1, c1); tick(1'b1, c2); tick(1'b1, c3);
    tick(1'b1, c4); tick(1'b1, c5); tick(1'b1, c6); tick(1'b1, c7);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failCount++;
      $display("FAIL watchdog actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelClear();
    rstN = 1'b0;
    cardIn = 4'd0;
    @(negedge clk);

    // R1: reset state
    tick(1'b0, 4'd5);

    // R7: natural 9 against 3, later cards ignored (R11)
    playHand(4'd9, 4'd1, 4'd10, 4'd2, 4'd10, 4'd7, 4'd3, 4'd4);
    check("R7 R10", {60'd0, ledOut}, {60'd0, 10'b01_0011_1001});

    // R8: player stands on 7, idle tick, dealer on 5 draws a 4 (R9)
    playHand(4'd3, 4'd2, 4'd4, 4'd3, 4'd9, 4'd4, 4'd8, 4'd8);
    check("R9 R10", {60'd0, ledOut}, {60'd0, 10'b10_1001_0111});

    // R9: dealer on 3 stands against a player third card of 8
    playHand(4'd1, 4'd1, 4'd2, 4'd2, 4'd8, 4'd6, 4'd6, 4'd6);
    check("R9", {63'd0, dealerSeg2}, {63'd0, 7'b1111111});

    // R6 R10: tie with king and blank code 14
    playHand(4'd5, 4'd2, 4'd13, 4'd3, 4'd14, 4'd9, 4'd9, 4'd9);
    check("R6 R10", {60'd0, ledOut}, {60'd0, 10'b11_0101_0101});

    // R1: reset in the middle of a deal
    tick(1'b0, 4'd0);
    tick(1'b1, 4'd12); tick(1'b1, 4'd11);
    tick(1'b0, 4'd6);

    // random hands over the full code range
    for (int g = 0; g < 400; g++) begin
      playHand(4'($urandom_range(15, 0)), 4'($urandom_range(15, 0)),
               4'($urandom_range(15, 0)), 4'($urandom_range(15, 0)),
               4'($urandom_range(15, 0)), 4'($urandom_range(15, 0)),
               4'($urandom_range(15, 0)), 4'($urandom_range(15, 0)));
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule